// File: doc/BRIEF.md
# Echo Channel State and Mute Controller

This block governs one pair of voice echo cancellers, called side A and side B, that share one adaptive filter. It stands between the decoded PCM samples of the pair's two timeslots and the output stage. Four control bits per side choose one of four functional states: muted, bypassed, adaptation frozen or adaptation running. The block turns that state into three things: quiet-code substitution on the sample stream, an adapt-enable flag for the filter, and a coefficient-clear request. The clear request comes with a completion flag, which rises once bypass has been held for a whole frame. The filter arithmetic lives elsewhere. The block only supplies the filter's reference sample and its control flags.

Two configuration bits select how the pair is used. In normal pairing the two sides serve two independent timeslots. In extended-delay pairing both halves of the filter serve one timeslot. In back-to-back pairing side A and side B cancel echo in the two directions of one timeslot. In the two paired modes the second timeslot of the group has no content of its own, so the block drives quiet code on it.

Samples arrive on a valid/ready stream, one per timeslot, and leave one cycle later through a single output register. The output stream follows the usual rules. A sample is taken when valid and ready are both high. While the output holds a sample that has not been taken, the input is not ready and the held output does not change. The control, status and frame-strobe pins are plain levels or pulses.

Top module: `ecsc_group_ctrl`

## Requirements
- R1: The quiet code depends on the coding law input `law`. It is 0x0000 for 0 (16-bit linear), 0x0080 for 1 (sign-magnitude), 0x00FF for 2 (mu-law) and 0x00D5 for 3 (A-law).
- R2: The control word has mute_r at bit 4 and mute_s at bit 5. With mute_r set, the sample's receive output and its filter reference are both quiet code. With mute_s set, the send output is quiet code. The other paths pass through.
- R3: The control word has its bypass bit at bit 3. With bypass set, receive input goes to receive output and send input goes to send output unchanged, the filter reference is quiet code, and the side's clear request is high whenever its state is bypassed.
- R4: The state output is encoded 0 = adapting, 1 = frozen, 2 = bypassed, 3 = muted. The priority is: any mute bit set gives muted, then bypass gives bypassed, then adapt_dis (bit 2) gives frozen. Adapt-enable is high only in the adapting state.
- R5: FRAMES_REQ sets the number of frames bypass must be held. Clear-done rises only after FRAMES_REQ+1 frame-strobe pulses have been seen while the side's state is bypassed. It falls as soon as the state leaves bypass, and leaving bypass restarts the count.
- R6: While a side's tone-bypass request is high, its adapt-enable is low, and the state is unaffected.
- R7: Pairing is reported on `pair_mode` as 0 = normal, 1 = extended delay, 2 = back-to-back. Bit 0 of side A selects extended delay. Back-to-back needs bit 1 set on both sides. Bit 0 of side B is ignored.
- R8: In extended delay, side B takes side A's control bits and state. In back-to-back, side B's mute bits are ignored. In both paired modes, a sample on slot 1 leaves with quiet code on all three outputs.
- R9: `in_ready` equals `!out_valid || out_ready`. An accepted sample appears on the outputs one clock later. While `out_valid` is high and `out_ready` is low, the output and its data hold.
- R10: After reset, `out_valid`, the clear flags and `pair_mode` are 0, and both states are adapting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| law | input | 2 | Coding law used to select the quiet code |
| ctl_a | input | 6 | Side A control word |
| ctl_b | input | 6 | Side B control word |
| tone_byp_a | input | 1 | Tone-bypass request, side A |
| tone_byp_b | input | 1 | Tone-bypass request, side B |
| frame_tick | input | 1 | One-cycle pulse at each frame boundary |
| in_valid | input | 1 | Input sample valid |
| in_ready | output | 1 | Input sample accepted this cycle when valid |
| in_slot | input | 1 | Timeslot of the sample (0 = side A, 1 = side B) |
| in_rin | input | DATA_W | Receive-path input sample |
| in_sin | input | DATA_W | Send-path input sample |
| out_valid | output | 1 | Output sample valid |
| out_ready | input | 1 | Downstream accepts the output sample |
| out_slot | output | 1 | Timeslot of the output sample |
| out_rout | output | DATA_W | Receive-path output |
| out_sout | output | DATA_W | Send-path output |
| out_ref | output | DATA_W | Reference sample for the filter |
| pair_mode | output | 2 | Decoded pairing |
| st_a | output | 2 | Side A state |
| st_b | output | 2 | Side B state |
| adapt_en_a | output | 1 | Side A filter adaptation enable |
| adapt_en_b | output | 1 | Side B filter adaptation enable |
| clr_req_a | output | 1 | Side A coefficient-clear request |
| clr_req_b | output | 1 | Side B coefficient-clear request |
| clr_done_a | output | 1 | Side A clear held for the full window |
| clr_done_b | output | 1 | Side B clear held for the full window |

## Verification
The bench builds the block with DATA_W = 16 and FRAMES_REQ = 2. A hold window of two frames gives three strobes to count, so an off-by-one in the clear counter shows up either one strobe early or one strobe late. It also leaves room to break off bypass halfway through and confirm that the count starts over. The 16-bit width puts the linear quiet code and the zero-extended 8-bit law codes side by side, so all four encodings can be told apart on the same outputs.

// File: rtl/ecsc_pkg.sv
package ecsc_pkg;

  typedef enum logic [1:0] {
    ST_ADAPT  = 2'd0,
    ST_FROZEN = 2'd1,
    ST_BYPASS = 2'd2,
    ST_MUTE   = 2'd3
  } chan_st_e;

  typedef enum logic [1:0] {
    PAIR_NORMAL = 2'd0,
    PAIR_EXT    = 2'd1,
    PAIR_B2B    = 2'd2
  } pair_e;

  // control word bit positions
  localparam int CB_EXT  = 0;
  localparam int CB_BBM  = 1;
  localparam int CB_ADIS = 2;
  localparam int CB_BYP  = 3;
  localparam int CB_MR   = 4;
  localparam int CB_MS   = 5;
  localparam int CTL_W   = 6;

  typedef struct packed {
    logic mute_s;
    logic mute_r;
    logic byp;
    logic adis;
  } side_ctl_t;

  typedef struct packed {
    logic mute_r;
    logic mute_s;
    logic byp;
    logic blank;
  } slot_ctl_t;

  function automatic logic [7:0] quiet_byte(input logic [1:0] law);
    case (law)
      2'd0:    quiet_byte = 8'h00;
      2'd1:    quiet_byte = 8'h80;
      2'd2:    quiet_byte = 8'hFF;
      default: quiet_byte = 8'hD5;
    endcase
  endfunction

endpackage

// File: rtl/ecsc_chan_fsm.sv
module ecsc_chan_fsm
  import ecsc_pkg::*;
#(
  parameter int FRAMES_REQ = 1
) (
  input  logic      clk,
  input  logic      rst_n,
  input  side_ctl_t eff,
  input  logic      tone_req,
  input  logic      frame_tick,
  output chan_st_e  state,
  output side_ctl_t eff_q,
  output logic      adapt_en,
  output logic      clr_req,
  output logic      clr_done
);

  localparam int CNT_MAX = FRAMES_REQ + 1;
  localparam int CW      = $clog2(CNT_MAX + 1);

  chan_st_e       st_d, st_q;
  logic [CW-1:0]  cnt_q;

  always_comb begin
    if (eff.mute_s || eff.mute_r) st_d = ST_MUTE;
    else if (eff.byp)             st_d = ST_BYPASS;
    else if (eff.adis)            st_d = ST_FROZEN;
    else                          st_d = ST_ADAPT;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q  <= ST_ADAPT;
      eff_q <= '0;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      eff_q <= eff;
      if (st_q != ST_BYPASS)
        cnt_q <= '0;
      else if (frame_tick && (cnt_q != CW'(CNT_MAX)))
        cnt_q <= cnt_q + 1'b1;
    end
  end

  assign state    = st_q;
  assign adapt_en = (st_q == ST_ADAPT) && !tone_req;
  assign clr_req  = (st_q == ST_BYPASS);
  assign clr_done = (st_q == ST_BYPASS) && (cnt_q == CW'(CNT_MAX));

  // R5
  done_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_done |-> clr_req);

  // R5
  done_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clr_done) |-> $past(frame_tick));

  // R6
  tone_gates_adapt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tone_req |-> !adapt_en);

  // R4
  mute_no_adapt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_MUTE) |-> !adapt_en);

endmodule

// File: rtl/ecsc_path.sv
module ecsc_path
  import ecsc_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        law,
  input  slot_ctl_t         sc,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              in_slot,
  input  logic [DATA_W-1:0] in_rin,
  input  logic [DATA_W-1:0] in_sin,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              out_slot,
  output logic [DATA_W-1:0] out_rout,
  output logic [DATA_W-1:0] out_sout,
  output logic [DATA_W-1:0] out_ref
);

  logic [DATA_W-1:0] qc, r_d, s_d, f_d;
  logic              fire;

  assign qc       = DATA_W'(quiet_byte(law));
  assign in_ready = !out_valid || out_ready;
  assign fire     = in_valid && in_ready;

  always_comb begin
    if (sc.blank) begin
      r_d = qc;
      s_d = qc;
      f_d = qc;
    end else begin
      r_d = sc.mute_r ? qc : in_rin;
      s_d = sc.mute_s ? qc : in_sin;
      f_d = (sc.mute_r || sc.byp) ? qc : in_rin;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_slot  <= 1'b0;
      out_rout  <= '0;
      out_sout  <= '0;
      out_ref   <= '0;
    end else begin
      if (fire) begin
        out_valid <= 1'b1;
        out_slot  <= in_slot;
        out_rout  <= r_d;
        out_sout  <= s_d;
        out_ref   <= f_d;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end

  // R9
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_rout) &&
                                   $stable(out_sout) && $stable(out_ref) &&
                                   $stable(out_slot)));

  // R9
  stall_blocks_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

endmodule

// File: rtl/ecsc_group_ctrl.sv
module ecsc_group_ctrl
  import ecsc_pkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int FRAMES_REQ = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        law,
  input  logic [5:0]        ctl_a,
  input  logic [5:0]        ctl_b,
  input  logic              tone_byp_a,
  input  logic              tone_byp_b,
  input  logic              frame_tick,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              in_slot,
  input  logic [DATA_W-1:0] in_rin,
  input  logic [DATA_W-1:0] in_sin,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              out_slot,
  output logic [DATA_W-1:0] out_rout,
  output logic [DATA_W-1:0] out_sout,
  output logic [DATA_W-1:0] out_ref,
  output logic [1:0]        pair_mode,
  output logic [1:0]        st_a,
  output logic [1:0]        st_b,
  output logic              adapt_en_a,
  output logic              adapt_en_b,
  output logic              clr_req_a,
  output logic              clr_req_b,
  output logic              clr_done_a,
  output logic              clr_done_b
);

  localparam int NSIDE = 2;

  pair_e     mode_d, mode_q;
  side_ctl_t raw_a, raw_b;
  side_ctl_t eff   [NSIDE];
  side_ctl_t eff_q [NSIDE];
  chan_st_e  st    [NSIDE];
  logic      tone  [NSIDE];
  logic      aen   [NSIDE];
  logic      creq  [NSIDE];
  logic      cdone [NSIDE];
  slot_ctl_t sc;

  assign raw_a = '{mute_s: ctl_a[CB_MS], mute_r: ctl_a[CB_MR],
                   byp: ctl_a[CB_BYP], adis: ctl_a[CB_ADIS]};
  assign raw_b = '{mute_s: ctl_b[CB_MS], mute_r: ctl_b[CB_MR],
                   byp: ctl_b[CB_BYP], adis: ctl_b[CB_ADIS]};

  always_comb begin
    if (ctl_a[CB_EXT])                     mode_d = PAIR_EXT;
    else if (ctl_a[CB_BBM] && ctl_b[CB_BBM]) mode_d = PAIR_B2B;
    else                                   mode_d = PAIR_NORMAL;
  end

  always_comb begin
    eff[0] = raw_a;
    case (mode_d)
      PAIR_EXT: eff[1] = raw_a;
      PAIR_B2B: eff[1] = '{mute_s: 1'b0, mute_r: 1'b0,
                           byp: raw_b.byp, adis: raw_b.adis};
      default:  eff[1] = raw_b;
    endcase
  end

  assign tone[0] = tone_byp_a;
  assign tone[1] = tone_byp_b;

  always_ff @(posedge clk) begin
    if (!rst_n) mode_q <= PAIR_NORMAL;
    else        mode_q <= mode_d;
  end

  for (genvar g = 0; g < NSIDE; g++) begin : g_side
    ecsc_chan_fsm #(.FRAMES_REQ(FRAMES_REQ)) u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .eff        (eff[g]),
      .tone_req   (tone[g]),
      .frame_tick (frame_tick),
      .state      (st[g]),
      .eff_q      (eff_q[g]),
      .adapt_en   (aen[g]),
      .clr_req    (creq[g]),
      .clr_done   (cdone[g])
    );
  end

  always_comb begin
    if (!in_slot)
      sc = '{mute_r: eff_q[0].mute_r, mute_s: eff_q[0].mute_s,
             byp: eff_q[0].byp, blank: 1'b0};
    else if (mode_q != PAIR_NORMAL)
      sc = '{mute_r: 1'b0, mute_s: 1'b0, byp: 1'b0, blank: 1'b1};
    else
      sc = '{mute_r: eff_q[1].mute_r, mute_s: eff_q[1].mute_s,
             byp: eff_q[1].byp, blank: 1'b0};
  end

  ecsc_path #(.DATA_W(DATA_W)) u_path (
    .clk       (clk),
    .rst_n     (rst_n),
    .law       (law),
    .sc        (sc),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_slot   (in_slot),
    .in_rin    (in_rin),
    .in_sin    (in_sin),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_slot  (out_slot),
    .out_rout  (out_rout),
    .out_sout  (out_sout),
    .out_ref   (out_ref)
  );

  assign pair_mode  = mode_q;
  assign st_a       = st[0];
  assign st_b       = st[1];
  assign adapt_en_a = aen[0];
  assign adapt_en_b = aen[1];
  assign clr_req_a  = creq[0];
  assign clr_req_b  = creq[1];
  assign clr_done_a = cdone[0];
  assign clr_done_b = cdone[1];

  // R8
  ext_follows_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == PAIR_EXT) |-> (st_b == st_a));

  // R7
  ext_from_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pair_mode == PAIR_EXT) |-> $past(ctl_a[CB_EXT]));

endmodule

// File: tb/tb_ecsc_group_ctrl.sv
module tb_ecsc_group_ctrl;

  localparam int DW = 16;
  localparam logic [15:0] RIN = 16'h1234;
  localparam logic [15:0] SIN = 16'h5678;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] law = 2'd0;
  logic [5:0] ctl_a = '0, ctl_b = '0;
  logic tone_byp_a = 1'b0, tone_byp_b = 1'b0, frame_tick = 1'b0;
  logic in_valid = 1'b0, in_slot = 1'b0, out_ready = 1'b1;
  logic [DW-1:0] in_rin = '0, in_sin = '0;
  logic in_ready, out_valid, out_slot;
  logic [DW-1:0] out_rout, out_sout, out_ref;
  logic [1:0] pair_mode, st_a, st_b;
  logic adapt_en_a, adapt_en_b, clr_req_a, clr_req_b, clr_done_a, clr_done_b;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  ecsc_group_ctrl #(.DATA_W(DW), .FRAMES_REQ(2)) dut (.*);

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic set_ctl(input logic [5:0] a, input logic [5:0] b, input logic [1:0] lw);
    @(negedge clk);
    ctl_a = a; ctl_b = b; law = lw;
    @(negedge clk);
  endtask

  task automatic send(input logic slot, input logic [15:0] r, input logic [15:0] s);
    @(negedge clk);
    in_valid = 1'b1; in_slot = slot; in_rin = r; in_sin = s;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic tick();
    @(negedge clk); frame_tick = 1'b1;
    @(negedge clk); frame_tick = 1'b0;
  endtask

  typedef struct packed {
    logic [5:0]  ca;
    logic [1:0]  lw;
    logic        slot;
    logic [15:0] r, s, f;
    logic [1:0]  st;
    logic        aen;
  } vec_t;

  localparam vec_t TBL [8] = '{
    '{6'h00, 2'd0, 1'b0, 16'h1234, 16'h5678, 16'h1234, 2'd0, 1'b1},
    '{6'h10, 2'd2, 1'b0, 16'h00FF, 16'h5678, 16'h00FF, 2'd3, 1'b0},
    '{6'h20, 2'd3, 1'b0, 16'h1234, 16'h00D5, 16'h1234, 2'd3, 1'b0},
    '{6'h30, 2'd1, 1'b0, 16'h0080, 16'h0080, 16'h0080, 2'd3, 1'b0},
    '{6'h08, 2'd0, 1'b0, 16'h1234, 16'h5678, 16'h0000, 2'd2, 1'b0},
    '{6'h28, 2'd2, 1'b0, 16'h1234, 16'h00FF, 16'h00FF, 2'd3, 1'b0},
    '{6'h04, 2'd0, 1'b0, 16'h1234, 16'h5678, 16'h1234, 2'd1, 1'b0},
    '{6'h10, 2'd0, 1'b1, 16'h1234, 16'h5678, 16'h1234, 2'd3, 1'b0}
  };

  initial begin
    #(20 * 100000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10 out_valid", 16'(out_valid), 16'h0);
    chk("R10 st_a", 16'(st_a), 16'h0);
    chk("R10 clr_done_a", 16'(clr_done_a), 16'h0);
    chk("R10 pair_mode", 16'(pair_mode), 16'h0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 R2 R3 R4: table walk in normal pairing
    foreach (TBL[i]) begin
      set_ctl(TBL[i].ca, 6'h00, TBL[i].lw);
      send(TBL[i].slot, RIN, SIN);
      chk($sformatf("R9 valid row%0d", i), 16'(out_valid), 16'h1);
      chk($sformatf("R2 R3 rout row%0d", i), out_rout, TBL[i].r);
      chk($sformatf("R2 R3 sout row%0d", i), out_sout, TBL[i].s);
      chk($sformatf("R1 R2 ref row%0d", i), out_ref, TBL[i].f);
      chk($sformatf("R4 state row%0d", i), 16'(st_a), 16'(TBL[i].st));
      chk($sformatf("R4 adapt row%0d", i), 16'(adapt_en_a), 16'(TBL[i].aen));
    end

    // R3 clear request in bypass
    set_ctl(6'h08, 6'h00, 2'd0);
    chk("R3 clr_req_a", 16'(clr_req_a), 16'h1);
    chk("R3 clr_req_b idle", 16'(clr_req_b), 16'h0);

    // R5 three strobes needed with FRAMES_REQ=2
    tick(); tick();
    chk("R5 not done after 2 ticks", 16'(clr_done_a), 16'h0);
    tick();
    chk("R5 done after 3 ticks", 16'(clr_done_a), 16'h1);
    set_ctl(6'h00, 6'h00, 2'd0);
    chk("R5 done drops on exit", 16'(clr_done_a), 16'h0);
    // R5 interrupted bypass restarts count
    set_ctl(6'h08, 6'h00, 2'd0);
    tick(); tick();
    set_ctl(6'h00, 6'h00, 2'd0);
    set_ctl(6'h08, 6'h00, 2'd0);
    tick(); tick();
    chk("R5 restart count", 16'(clr_done_a), 16'h0);
    tick();
    chk("R5 done after restart", 16'(clr_done_a), 16'h1);

    // R6 tone gates adaptation
    set_ctl(6'h00, 6'h00, 2'd0);
    chk("R6 adapt before tone", 16'(adapt_en_a), 16'h1);
    @(negedge clk); tone_byp_a = 1'b1;
    #1;
    chk("R6 adapt gated", 16'(adapt_en_a), 16'h0);
    chk("R6 state kept", 16'(st_a), 16'h0);
    chk("R6 side B unaffected", 16'(adapt_en_b), 16'h1);
    @(negedge clk); tone_byp_a = 1'b0;

    // R7 R8 extended delay; side B bits ignored
    set_ctl(6'h01, 6'h15, 2'd2);
    chk("R7 ext mode", 16'(pair_mode), 16'h1);
    chk("R8 ext st_b follows a", 16'(st_b), 16'h0);
    send(1'b1, RIN, SIN);
    chk("R8 ext slot1 rout", out_rout, 16'h00FF);
    chk("R8 ext slot1 sout", out_sout, 16'h00FF);
    chk("R8 ext slot1 ref", out_ref, 16'h00FF);
    send(1'b0, RIN, SIN);
    chk("R8 ext slot0 rout", out_rout, RIN);

    // R7 back-to-back needs both bits
    set_ctl(6'h02, 6'h00, 2'd0);
    chk("R7 bbm only A -> normal", 16'(pair_mode), 16'h0);
    set_ctl(6'h12, 6'h2A, 2'd3);
    chk("R7 b2b mode", 16'(pair_mode), 16'h2);
    chk("R8 b2b st_b bypass, mute ignored", 16'(st_b), 16'h2);
    chk("R4 b2b st_a mute", 16'(st_a), 16'h3);
    send(1'b0, RIN, SIN);
    chk("R8 b2b slot0 rout", out_rout, 16'h00D5);
    chk("R8 b2b slot0 sout", out_sout, SIN);
    send(1'b1, RIN, SIN);
    chk("R8 b2b slot1 sout", out_sout, 16'h00D5);

    // R9 back-pressure
    set_ctl(6'h00, 6'h00, 2'd0);
    @(negedge clk);
    out_ready = 1'b0;
    in_valid = 1'b1; in_slot = 1'b0; in_rin = 16'hAAAA; in_sin = 16'hBBBB;
    @(negedge clk);
    chk("R9 held valid", 16'(out_valid), 16'h1);
    chk("R9 in_ready low", 16'(in_ready), 16'h0);
    in_rin = 16'hCCCC; in_sin = 16'hDDDD;
    @(negedge clk); @(negedge clk);
    chk("R9 held rout", out_rout, 16'hAAAA);
    chk("R9 held sout", out_sout, 16'hBBBB);
    out_ready = 1'b1;
    #1;
    chk("R9 ready follows out_ready", 16'(in_ready), 16'h1);
    @(negedge clk);
    in_valid = 1'b0;
    chk("R9 next sample", out_rout, 16'hCCCC);
    @(negedge clk);
    chk("R9 drained", 16'(out_valid), 16'h0);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule